// File: doc/BRIEF.md
# Partition-Control Register Access Gate

This block decides what happens when software reads or writes the hypervisor's partition-control system register. It is given the decoded system-register encoding and the state that governs access. That state covers the current privilege level, the hypervisor enable, the two nested-virtualization controls, whether the top privilege level exists and asks for lower-level accesses to be trapped, the debug halt and secure-debug-disable flags, and whether the register is implemented at all. From these it selects exactly one outcome: perform the access, raise an undefined-instruction exception, trap to level 2, trap to level 3, or redirect the access to a memory-backed copy of the register.

On a trap it supplies the exception syndrome class. On a redirect it supplies the fixed byte offset of the copy within the nested-virtualization memory page. The decision is combinational, and one output register stage follows it. A request is presented for one cycle, and its verdict appears on the outputs at the next rising clock edge. Encodings other than this register produce no verdict, so that other decode logic can handle them.

Top module: `pctl_access_gate`

## Requirements
- R1: A verdict (`out_valid` = 1) is produced only when `acc_valid` is 1 and the encoding equals op0=0b11, op1=0b100, CRn=0b1010, CRm=0b0100, op2=0b000. Otherwise `out_valid`, `outcome`, `syn_class` and `mem_offset` are all 0.
- R2: If either `feat_present` or `ctrl_cap_present` is 0, the outcome is undefined at every privilege level.
- R3: An access from level 0 (`cur_level` = 0) is undefined.
- R4: At level 1, with `hyp_enabled`, `nest_base` and `nest_mem` all 1, the outcome is redirect and `mem_offset` is 0x930.
- R5: At level 1, with `hyp_enabled` = 1, `nest_base` = 1 and `nest_mem` = 0, the outcome is trap to level 3 when `lvl3_present` and `lvl3_trap_lower` are both 1. Otherwise the outcome is trap to level 2.
- R6: Any other level-1 combination is undefined. This includes `nest_mem` = 1 with `nest_base` = 0, and `hyp_enabled` = 0.
- R7: At level 2, the outcome is trap to level 3 when `lvl3_present` and `lvl3_trap_lower` are both 1. Otherwise the outcome is perform.
- R8: Where R5 or R7 would give trap to level 3 while `dbg_halted` and `dbg_secure_off` are both 1, the outcome is undefined instead.
- R9: At level 3, with the register present, the outcome is perform.
- R10: `outcome` is one-hot whenever `out_valid` is 1. The bit positions are: bit0 perform, bit1 undefined, bit2 trap to level 2, bit3 trap to level 3, bit4 redirect. `syn_class` is 0x18 on either trap and 0 otherwise. `mem_offset` is 0 unless the outcome is redirect.
- R11: The outputs reflect the inputs sampled at the preceding rising edge. An active-low `rst_n` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A system-register access is presented |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| hyp_enabled | input | 1 | Level 2 is enabled in the current security state |
| nest_base | input | 1 | Nested virtualization: trap level-1 accesses to hypervisor registers |
| nest_mem | input | 1 | Nested virtualization: redirect those accesses to memory |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl3_trap_lower | input | 1 | Level 3 traps lower-level accesses to partition registers |
| dbg_halted | input | 1 | Core is halted in debug state |
| dbg_secure_off | input | 1 | Secure debug is disabled |
| feat_present | input | 1 | The partitioning feature is implemented |
| ctrl_cap_present | input | 1 | The hypervisor-control capability is implemented |
| out_valid | output | 1 | A verdict is presented for this register |
| outcome | output | 5 | One-hot verdict (see R10) |
| syn_class | output | 6 | Exception syndrome class on traps |
| mem_offset | output | 12 | Byte offset of the memory-backed copy on redirect |

## Verification
The matching encoding is driven with every combination of privilege level, hypervisor and nested controls, top-level trap bits, debug flags and presence flags. This separates the redirect, trap and undefined branches at level 1, and it shows the debug override acting only on traps to level 3, never on traps to level 2. Encodings with a single field bit flipped, and cycles with `acc_valid` low, show that no verdict leaks out for foreign registers. A sweep with the presence flags cleared shows that absence overrides every level, including level 3.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
    localparam int OC_W  = 5;
    localparam int SYN_W = 6;
    localparam int OFS_W = 12;
    localparam int LVL_W = 2;

    localparam int OC_PERFORM  = 0;
    localparam int OC_UNDEF    = 1;
    localparam int OC_TRAP_L2  = 2;
    localparam int OC_TRAP_L3  = 3;
    localparam int OC_REDIRECT = 4;

    typedef struct packed {
        logic             vld;
        logic [OC_W-1:0]  oc;
        logic [SYN_W-1:0] syn;
        logic [OFS_W-1:0] ofs;
    } gate_res_t;
endpackage

// File: rtl/pctl_enc_match.sv
module pctl_enc_match #(
    parameter logic [1:0] ENC_OP0 = 2'b11,
    parameter logic [2:0] ENC_OP1 = 3'b100,
    parameter logic [3:0] ENC_CRN = 4'b1010,
    parameter logic [3:0] ENC_CRM = 4'b0100,
    parameter logic [2:0] ENC_OP2 = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    logic [4:0] fld_eq;

    always_comb begin
        fld_eq[0] = (op0 == ENC_OP0);
        fld_eq[1] = (op1 == ENC_OP1);
        fld_eq[2] = (crn == ENC_CRN);
        fld_eq[3] = (crm == ENC_CRM);
        fld_eq[4] = (op2 == ENC_OP2);
        hit       = &fld_eq;
    end
endmodule

// File: rtl/pctl_upper_trap.sv
module pctl_upper_trap (
    input  logic lvl3_present,
    input  logic lvl3_trap_lower,
    input  logic dbg_halted,
    input  logic dbg_secure_off,
    output logic take_l3,
    output logic halt_undef
);
    logic want_l3;
    logic halt_block;

    always_comb begin
        want_l3    = lvl3_present && lvl3_trap_lower;
        halt_block = dbg_halted && dbg_secure_off;
        take_l3    = want_l3 && !halt_block;
        halt_undef = want_l3 && halt_block;
    end

    // R8
    always_comb begin
        halt_excl_chk: assert (!(take_l3 && halt_undef));
    end
endmodule

// File: rtl/pctl_decide.sv
module pctl_decide
    import pctl_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    input  logic             reg_present,
    input  logic             hyp_enabled,
    input  logic             nest_base,
    input  logic             nest_mem,
    input  logic             take_l3,
    input  logic             halt_undef,
    output logic [OC_W-1:0]  oc
);
    // upper-level verdict shared by the level-1 trap path and the level-2 path
    function automatic logic [OC_W-1:0] upper_pick(input logic t3, input logic hu,
                                                   input int fallback);
        logic [OC_W-1:0] r;
        r = '0;
        if (hu)      r[OC_UNDEF]   = 1'b1;
        else if (t3) r[OC_TRAP_L3] = 1'b1;
        else         r[fallback]   = 1'b1;
        return r;
    endfunction

    always_comb begin
        oc = '0;
        if (!reg_present) begin
            oc[OC_UNDEF] = 1'b1;
        end else begin
            case (level)
                2'd0: oc[OC_UNDEF] = 1'b1;
                2'd1: begin
                    if (hyp_enabled && nest_base && nest_mem)
                        oc[OC_REDIRECT] = 1'b1;
                    else if (hyp_enabled && nest_base)
                        oc = upper_pick(take_l3, halt_undef, OC_TRAP_L2);
                    else
                        oc[OC_UNDEF] = 1'b1;
                end
                2'd2:    oc = upper_pick(take_l3, halt_undef, OC_PERFORM);
                default: oc[OC_PERFORM] = 1'b1;
            endcase
        end
    end

    // R10
    always_comb begin
        decide_onehot_chk: assert ($onehot(oc));
    end
endmodule

// File: rtl/pctl_access_gate.sv
module pctl_access_gate
    import pctl_pkg::*;
#(
    parameter logic [SYN_W-1:0] SYN_EC  = 6'h18,
    parameter logic [OFS_W-1:0] MEM_OFS = 12'h930
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [1:0]       acc_op0,
    input  logic [2:0]       acc_op1,
    input  logic [3:0]       acc_crn,
    input  logic [3:0]       acc_crm,
    input  logic [2:0]       acc_op2,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             hyp_enabled,
    input  logic             nest_base,
    input  logic             nest_mem,
    input  logic             lvl3_present,
    input  logic             lvl3_trap_lower,
    input  logic             dbg_halted,
    input  logic             dbg_secure_off,
    input  logic             feat_present,
    input  logic             ctrl_cap_present,
    output logic             out_valid,
    output logic [OC_W-1:0]  outcome,
    output logic [SYN_W-1:0] syn_class,
    output logic [OFS_W-1:0] mem_offset
);
    logic            enc_hit;
    logic            take_l3;
    logic            halt_undef;
    logic [OC_W-1:0] oc_raw;
    gate_res_t       res_d, res_q;

    pctl_enc_match i_match (
        .op0 (acc_op0), .op1 (acc_op1), .crn (acc_crn),
        .crm (acc_crm), .op2 (acc_op2), .hit (enc_hit)
    );

    pctl_upper_trap i_upper (
        .lvl3_present    (lvl3_present),
        .lvl3_trap_lower (lvl3_trap_lower),
        .dbg_halted      (dbg_halted),
        .dbg_secure_off  (dbg_secure_off),
        .take_l3         (take_l3),
        .halt_undef      (halt_undef)
    );

    pctl_decide i_decide (
        .level       (cur_level),
        .reg_present (feat_present && ctrl_cap_present),
        .hyp_enabled (hyp_enabled),
        .nest_base   (nest_base),
        .nest_mem    (nest_mem),
        .take_l3     (take_l3),
        .halt_undef  (halt_undef),
        .oc          (oc_raw)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = acc_valid && enc_hit;
        if (res_d.vld) begin
            res_d.oc = oc_raw;
            if (oc_raw[OC_TRAP_L2] || oc_raw[OC_TRAP_L3]) res_d.syn = SYN_EC;
            if (oc_raw[OC_REDIRECT])                      res_d.ofs = MEM_OFS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.vld;
    assign outcome    = res_q.oc;
    assign syn_class  = res_q.syn;
    assign mem_offset = res_q.ofs;

    // R1
    no_verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (outcome == '0 && syn_class == '0 && mem_offset == '0));
    // R1
    no_req_no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> !out_valid);
    // R10
    onehot_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(outcome));
    // R10
    syn_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((outcome[OC_TRAP_L2] || outcome[OC_TRAP_L3]) == (syn_class == SYN_EC)));
    // R4
    offset_on_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (outcome[OC_REDIRECT] == (mem_offset == MEM_OFS)));
    // R3
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_level) == 2'd0) |-> outcome[OC_UNDEF]);
    // R2
    absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(feat_present && ctrl_cap_present)) |-> outcome[OC_UNDEF]);
    // R9
    lvl3_perform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_level) == 2'd3 && $past(feat_present && ctrl_cap_present))
        |-> outcome[OC_PERFORM]);
    // R8
    halt_no_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(dbg_halted && dbg_secure_off)) |-> !outcome[OC_TRAP_L3]);
endmodule

// File: tb/test_pctl_access_gate.sv
module test_pctl_access_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op0 = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [1:0]  cur_level = '0;
    logic        hyp_enabled = 1'b0, nest_base = 1'b0, nest_mem = 1'b0;
    logic        lvl3_present = 1'b0, lvl3_trap_lower = 1'b0;
    logic        dbg_halted = 1'b0, dbg_secure_off = 1'b0;
    logic        feat_present = 1'b0, ctrl_cap_present = 1'b0;
    logic        out_valid;
    logic [4:0]  outcome;
    logic [5:0]  syn_class;
    logic [11:0] mem_offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected verdict for the request driven one cycle earlier
    logic        exp_vld = 1'b0;
    logic [4:0]  exp_oc = '0;
    logic [5:0]  exp_syn = '0;
    logic [11:0] exp_ofs = '0;
    string       exp_tag = "R11";

    always #4 clk = ~clk;

    pctl_access_gate i_pctl_access_gate (
        .clk, .rst_n, .acc_valid, .acc_op0, .acc_op1, .acc_crn, .acc_crm, .acc_op2,
        .cur_level, .hyp_enabled, .nest_base, .nest_mem, .lvl3_present,
        .lvl3_trap_lower, .dbg_halted, .dbg_secure_off, .feat_present,
        .ctrl_cap_present, .out_valid, .outcome, .syn_class, .mem_offset
    );

    task automatic compare_now();
        checks++;
        if (out_valid !== exp_vld || outcome !== exp_oc ||
            syn_class !== exp_syn || mem_offset !== exp_ofs) begin
            failures++;
            $display("FAIL %s: got vld=%b oc=%b syn=%h ofs=%h expected vld=%b oc=%b syn=%h ofs=%h",
                     exp_tag, out_valid, outcome, syn_class, mem_offset,
                     exp_vld, exp_oc, exp_syn, exp_ofs);
        end
    endtask

    // behavioural reference: verdict index 0 perform,1 undef,2 trap2,3 trap3,4 redirect
    task automatic predict();
        int    v;
        string t;
        bit    up3;
        up3 = lvl3_present && lvl3_trap_lower;
        if (!(acc_valid && acc_op0 == 2'b11 && acc_op1 == 3'b100 && acc_crn == 4'b1010 &&
              acc_crm == 4'b0100 && acc_op2 == 3'b000)) begin
            exp_vld = 0; exp_oc = 0; exp_syn = 0; exp_ofs = 0; exp_tag = "R1";
            return;
        end
        if (!(feat_present && ctrl_cap_present)) begin v = 1; t = "R2"; end
        else if (cur_level == 0) begin v = 1; t = "R3"; end
        else if (cur_level == 3) begin v = 0; t = "R9"; end
        else if (cur_level == 1) begin
            if (hyp_enabled && nest_base && nest_mem) begin v = 4; t = "R4"; end
            else if (hyp_enabled && nest_base) begin
                t = "R5";
                v = up3 ? 3 : 2;
            end else begin v = 1; t = "R6"; end
        end else begin
            t = "R7";
            v = up3 ? 3 : 0;
        end
        if (v == 3 && dbg_halted && dbg_secure_off) begin v = 1; t = "R8"; end
        exp_vld = 1;
        exp_oc  = 5'(1 << v);
        exp_syn = (v == 2 || v == 3) ? 6'h18 : 6'h00;
        exp_ofs = (v == 4) ? 12'h930 : 12'h000;
        exp_tag = (v == 2 || v == 3 || v == 4) ? {t, "/R10"} : t;
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        compare_now();
    endtask

    task automatic set_match();
        acc_valid = 1; acc_op0 = 2'b11; acc_op1 = 3'b100;
        acc_crn = 4'b1010; acc_crm = 4'b0100; acc_op2 = 3'b000;
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        exp_tag = "R11";
        compare_now();
        rst_n = 1'b1;
        @(negedge clk);
        exp_tag = "R11";
        compare_now();

        // exhaustive sweep of the controlling inputs for the matching encoding
        set_match();
        for (int c = 0; c < 4096; c++) begin
            cur_level        = c[1:0];
            hyp_enabled      = c[2];
            nest_base        = c[3];
            nest_mem         = c[4];
            lvl3_present     = c[5];
            lvl3_trap_lower  = c[6];
            dbg_halted       = c[7];
            dbg_secure_off   = c[8];
            feat_present     = !c[9];
            ctrl_cap_present = !c[10];
            acc_valid        = !c[11];
            step();
        end

        // R1: single-bit mismatches in each encoding field, with a verdict-rich state
        cur_level = 2; feat_present = 1; ctrl_cap_present = 1;
        lvl3_present = 1; lvl3_trap_lower = 1; dbg_halted = 0; dbg_secure_off = 0;
        for (int b = 0; b < 16; b++) begin
            set_match();
            if (b < 2)       acc_op0[b]      = ~acc_op0[b];
            else if (b < 5)  acc_op1[b-2]    = ~acc_op1[b-2];
            else if (b < 9)  acc_crn[b-5]    = ~acc_crn[b-5];
            else if (b < 13) acc_crm[b-9]    = ~acc_crm[b-9];
            else             acc_op2[b-13]   = ~acc_op2[b-13];
            step();
            set_match();
            step();
        end

        // R11: reset in the middle clears outputs
        set_match();
        step();
        rst_n = 1'b0;
        #1;
        exp_vld = 0; exp_oc = 0; exp_syn = 0; exp_ofs = 0; exp_tag = "R11";
        compare_now();
        @(negedge clk);
        rst_n = 1'b1;
        acc_valid = 0;
        step();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule